// File: doc/BRIEF.md
# Byte/Word Configurable ROM Read Port

This block is a cycle-based model of the read side of a one-time-programmable memory. The memory holds 16-bit words and can be read either as whole words or as single bytes. A width select picks the organisation. In byte mode, the pin that carries data bit 15 in word mode is used instead as an extra low address bit. That bit chooses which half of the stored word appears on the low eight lanes, and the upper lanes stop driving. The outputs are driven only while chip enable and output enable are both low. With chip enable high the block is in standby and drives nothing.

Real tri-state pins are replaced by a 16-bit lane-enable vector, so the block can be synthesized. A lane that is not enabled reads as zero on the data bus. Access timing is counted in clock cycles:
- an address or enable change starts a full access-latency count;
- output enable has its own, shorter latency;
- until an access count completes, the bus keeps its previous value.

A flag for the high-voltage identification condition replaces the stored data with fixed identifier codes. A write port loads the array. Loading can only clear bits, as programming does.

Top module: `rom_rd_port`

## Requirements
- R1: After reset every lane enable is 0 and the data bus is 0. Every word never loaded reads 16'hFFFF.
- R2: With width select high (word mode) and both enables low, all 16 lane enables are 1 and the bus carries the stored word at the word address.
- R3: With width select low (byte mode) and the low-half select at 0, the bus carries bits 7:0 of the stored word on bits 7:0. The lane enables read 16'h00FF, so bits 15:8 are undriven and read 0.
- R4: In byte mode with the low-half select at 1, bits 15:8 of the stored word appear on bus bits 7:0, and the lane enables read 16'h00FF.
- R5: In word mode the low-half select has no effect: toggling it neither changes the bus nor restarts an access.
- R6: Output enable high with chip enable low forces all lane enables to 0 in the same cycle.
- R7: Chip enable high forces all lane enables to 0 in the same cycle, whatever output enable does. After chip enable returns low, the lanes stay off until a full address access completes.
- R8: With the identification flag high and word-address bits [ADDR_W-1:1] all zero, the bus carries 16'h0020 when address bit 0 is 0 and 16'h00B8 when it is 1. If any of those higher bits is 1, the stored word is read as usual.
- R9: An access starts when the address, width select, low-half select (byte mode only), identification flag or chip enable changes. The new value appears on the bus exactly ADDR_LAT rising edges after the access starts. Before that the bus holds its previous value.
- R10: After output enable falls, with the address access already complete, the lanes are enabled exactly OE_LAT rising edges later.
- R11: A load ANDs the given data into the stored word, so a load can only turn ones into zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide_sel | input | 1 | 1 = word organisation, 0 = byte organisation |
| half_sel | input | 1 | Byte mode: 0 = low half, 1 = high half (shares the bit-15 pin) |
| word_addr | input | ADDR_W | Word address |
| id_hv | input | 1 | Identification high-voltage condition present |
| load_en | input | 1 | Load strobe for the array |
| load_addr | input | ADDR_W | Word address to load |
| load_data | input | 16 | Data ANDed into the addressed word |
| dout | output | 16 | Data bus; lanes not enabled read 0 |
| lane_oe | output | 16 | Per-lane drive enable |

## Verification
The bench builds the block with ADDR_W = 6, ADDR_LAT = 5 and OE_LAT = 2. With 64 words, both the last word and the identification address pair can be reached with few loads. With an address latency of five cycles, the hold window before a new value appears is long enough to sample both inside it and at its end. Because the output-enable latency differs from the address latency, the two counts are checked as separate delays.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    localparam int WORD_W = 16;
    localparam int HALF_W = 8;

    localparam logic [HALF_W-1:0] MAKER_ID  = 8'h20;
    localparam logic [HALF_W-1:0] DEVICE_ID = 8'hB8;

    typedef enum logic {
        ORG_BYTE = 1'b0,
        ORG_WORD = 1'b1
    } org_e;

    // Arrange a stored word for the chosen organisation.
    function automatic logic [WORD_W-1:0] shape_word(org_e org, logic hi_half,
                                                     logic [WORD_W-1:0] word);
        logic [HALF_W-1:0] half;
        half = hi_half ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
        if (org == ORG_WORD) begin
            return word;
        end
        return {{(WORD_W-HALF_W){1'b0}}, half};
    endfunction

    function automatic logic [HALF_W-1:0] id_code(logic a0);
        return a0 ? DEVICE_ID : MAKER_ID;
    endfunction

endpackage

// File: rtl/rom_cell_array.sv
module rom_cell_array
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    // Blank cells hold all ones; loading only clears bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (ld_en) begin
            cells[ld_addr] <= cells[ld_addr] & ld_data;
        end
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer #(
    parameter int ADDR_LAT = 8,
    parameter int OE_LAT   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic ce_n,
    input  logic oe_n,
    output logic load_now,
    output logic access_ok,
    output logic oe_ok
);
    localparam int AW = $clog2(ADDR_LAT + 1);
    localparam int OW = $clog2(OE_LAT + 1);
    localparam logic [AW-1:0] A_LIM = AW'(ADDR_LAT);
    localparam logic [OW-1:0] O_LIM = OW'(OE_LAT);

    logic [AW-1:0] a_cnt, a_nxt;
    logic [OW-1:0] o_cnt;

    always_comb begin
        if (restart) begin
            a_nxt = AW'(1);
        end else if (a_cnt == A_LIM) begin
            a_nxt = a_cnt;
        end else begin
            a_nxt = a_cnt + AW'(1);
        end
    end

    assign load_now = !ce_n && (a_nxt == A_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_cnt     <= '0;
            access_ok <= 1'b0;
        end else begin
            a_cnt <= a_nxt;
            if (ce_n) begin
                access_ok <= 1'b0;
            end else if (load_now) begin
                access_ok <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || oe_n || ce_n) begin
            o_cnt <= '0;
        end else if (o_cnt != O_LIM) begin
            o_cnt <= o_cnt + OW'(1);
        end
    end

    assign oe_ok = (o_cnt == O_LIM);

endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  org_e              org,
    input  logic              hi_half,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] shaped
);
    logic id_window;

    assign id_window = id_hv && (addr[ADDR_W-1:1] == '0);

    always_comb begin
        if (id_window) begin
            shaped = {{(WORD_W-HALF_W){1'b0}}, id_code(addr[0])};
        end else begin
            shaped = shape_word(org, hi_half, word);
        end
    end

endmodule

// File: rtl/rom_rd_port.sv
module rom_rd_port
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int ADDR_LAT = 8,
    parameter int OE_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_sel,
    input  logic              half_sel,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              id_hv,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [15:0]       load_data,
    output logic [15:0]       dout,
    output logic [15:0]       lane_oe
);
    typedef struct packed {
        logic              off;
        org_e              org;
        logic              id;
        logic [ADDR_W-1:0] waddr;
        logic              half;
    } access_t;

    access_t cur_acc, last_acc;
    logic    restart, load_now, access_ok, oe_ok, drive, upper_ok;
    org_e    org, org_q;
    logic [WORD_W-1:0] raw_word, shaped, data_q;

    assign org = wide_sel ? ORG_WORD : ORG_BYTE;

    always_comb begin
        cur_acc.off   = ce_n;
        cur_acc.org   = org;
        cur_acc.id    = id_hv;
        cur_acc.waddr = word_addr;
        cur_acc.half  = (org == ORG_BYTE) ? half_sel : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_acc <= '1;
        end else begin
            last_acc <= cur_acc;
        end
    end

    assign restart = ce_n || (cur_acc != last_acc);

    rom_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (load_en),
        .ld_addr (load_addr),
        .ld_data (load_data),
        .rd_addr (word_addr),
        .rd_word (raw_word)
    );

    rom_lane_mux #(.ADDR_W(ADDR_W)) u_mux (
        .org     (org),
        .hi_half (half_sel),
        .id_hv   (id_hv),
        .addr    (word_addr),
        .word    (raw_word),
        .shaped  (shaped)
    );

    rom_access_timer #(.ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .load_now  (load_now),
        .access_ok (access_ok),
        .oe_ok     (oe_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            org_q  <= ORG_BYTE;
        end else if (load_now) begin
            data_q <= shaped;
            org_q  <= org;
        end
    end

    assign drive    = !ce_n && !oe_n && oe_ok && access_ok;
    assign upper_ok = (org == ORG_WORD) && (org_q == ORG_WORD);

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        if (g < HALF_W) begin : g_low
            assign lane_oe[g] = drive;
        end else begin : g_high
            assign lane_oe[g] = drive && upper_ok;
        end
    end

    assign dout = data_q & lane_oe;

endmodule

// File: rtl/rom_rd_port_chk.sv
module rom_rd_port_chk #(
    parameter int ADDR_W   = 8,
    parameter int ADDR_LAT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              wide_sel,
    input logic [ADDR_W-1:0] word_addr,
    input logic [15:0]       dout,
    input logic [15:0]       lane_oe
);
    a_r6_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> lane_oe == 16'h0);

    a_r7_standby: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> lane_oe == 16'h0);

    a_r3_upper_float: assert property (@(posedge clk) disable iff (rst)
        !wide_sel |-> lane_oe[15:8] == 8'h0);

    a_r10_oe_delay: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> lane_oe == 16'h0);

    a_r7_wake_delay: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> lane_oe == 16'h0);

    if (ADDR_LAT >= 2) begin : g_hold
        a_r9_hold: assert property (@(posedge clk) disable iff (rst)
            ((lane_oe != 16'h0) && (word_addr != $past(word_addr)))
            |=> (ce_n || oe_n || (wide_sel != $past(wide_sel)) || $stable(dout)));
    end

endmodule

bind rom_rd_port rom_rd_port_chk #(.ADDR_W(ADDR_W), .ADDR_LAT(ADDR_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .wide_sel  (wide_sel),
    .word_addr (word_addr),
    .dout      (dout),
    .lane_oe   (lane_oe)
);

// File: tb/tb_rom_rd_port.sv
module tb_rom_rd_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int ALAT = 5;
    localparam int OLAT = 2;

    logic          clk = 1'b0;
    logic          rst, ce_n, oe_n, wide_sel, half_sel, id_hv, load_en;
    logic [AW-1:0] word_addr, load_addr;
    logic [15:0]   load_data, dout, lane_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_rd_port #(.ADDR_W(AW), .ADDR_LAT(ALAT), .OE_LAT(OLAT)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
        .half_sel(half_sel), .word_addr(word_addr), .id_hv(id_hv),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .dout(dout), .lane_oe(lane_oe)
    );

    // {addr, wide, half, id, expected dout, expected lanes}
    localparam logic [40:0] VECS [12] = '{
        {6'd1,  1'b1, 1'b0, 1'b0, 16'hA55A, 16'hFFFF},  // R2
        {6'd2,  1'b1, 1'b0, 1'b0, 16'h1234, 16'hFFFF},  // R2
        {6'd63, 1'b1, 1'b0, 1'b0, 16'h8001, 16'hFFFF},  // R2 last word
        {6'd10, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF},  // R1 blank word
        {6'd1,  1'b0, 1'b0, 1'b0, 16'h005A, 16'h00FF},  // R3
        {6'd1,  1'b0, 1'b1, 1'b0, 16'h00A5, 16'h00FF},  // R4
        {6'd2,  1'b0, 1'b1, 1'b0, 16'h0012, 16'h00FF},  // R4
        {6'd63, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h00FF},  // R3
        {6'd0,  1'b1, 1'b0, 1'b1, 16'h0020, 16'hFFFF},  // R8 maker
        {6'd1,  1'b1, 1'b0, 1'b1, 16'h00B8, 16'hFFFF},  // R8 device
        {6'd0,  1'b0, 1'b1, 1'b1, 16'h0020, 16'h00FF},  // R8 byte mode
        {6'd2,  1'b1, 1'b0, 1'b1, 16'h1234, 16'hFFFF}   // R8 outside window
    };

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(logic [AW-1:0] a, logic [15:0] d);
        load_en = 1'b1; load_addr = a; load_data = d;
        tick(1);
        load_en = 1'b0;
    endtask

    task automatic access(logic [AW-1:0] a, logic w, logic h, logic g);
        ce_n = 1'b1;
        tick(1);
        ce_n = 1'b0; word_addr = a; wide_sel = w; half_sel = h; id_hv = g;
        tick(ALAT);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; wide_sel = 1'b1; half_sel = 1'b0;
        id_hv = 1'b0; load_en = 1'b0; word_addr = '0; load_addr = '0; load_data = '0;
        tick(3);
        check("R1 reset lanes", lane_oe, 16'h0000);
        check("R1 reset bus", dout, 16'h0000);
        rst = 1'b0;
        tick(1);

        load(6'd1, 16'hA55A);
        load(6'd2, 16'h1234);
        load(6'd5, 16'h00FF);
        load(6'd63, 16'h8001);
        oe_n = 1'b0;

        foreach (VECS[i]) begin
            access(VECS[i][40:35], VECS[i][34], VECS[i][33], VECS[i][32]);
            check($sformatf("vector %0d bus", i), dout, VECS[i][31:16]);
            check($sformatf("vector %0d lanes", i), lane_oe, VECS[i][15:0]);
        end

        // R5: half select toggled in word mode
        access(6'd1, 1'b1, 1'b0, 1'b0);
        half_sel = 1'b1;
        tick(1);
        check("R5 bus next cycle", dout, 16'hA55A);
        tick(ALAT);
        check("R5 bus later", dout, 16'hA55A);
        check("R5 lanes", lane_oe, 16'hFFFF);

        // R9: hold old word during the access count
        word_addr = 6'd2;
        tick(ALAT - 1);
        check("R9 hold", dout, 16'hA55A);
        tick(1);
        check("R9 new word", dout, 16'h1234);

        // R6 / R10: output enable gating and delay
        oe_n = 1'b1;
        #1;
        check("R6 oe off", lane_oe, 16'h0000);
        tick(2);
        oe_n = 1'b0;
        tick(OLAT - 1);
        check("R10 before delay", lane_oe, 16'h0000);
        tick(1);
        check("R10 after delay", lane_oe, 16'hFFFF);
        check("R10 bus", dout, 16'h1234);

        // R7: standby and wake-up delay
        ce_n = 1'b1;
        #1;
        check("R7 standby", lane_oe, 16'h0000);
        tick(2);
        check("R7 standby held", lane_oe, 16'h0000);
        ce_n = 1'b0;
        tick(ALAT - 1);
        check("R7 wake pending", lane_oe, 16'h0000);
        tick(1);
        check("R7 wake done", lane_oe, 16'hFFFF);

        // R11: a load only clears bits
        load(6'd5, 16'h0FF0);
        access(6'd5, 1'b1, 1'b0, 1'b0);
        check("R11 and-load", dout, 16'h00F0);

        done = 1'b1;
        report();
    end

endmodule